// File: doc/BRIEF.md
# Multichannel DAC Code Register Bank

This block keeps the digital side of a twelve-channel, 8-bit tuning converter. It holds one 8-bit code per channel, where code N stands for an output of N/256 of the reference and 0 means ground. For channels 5 to 12, whose pins can also serve as digital I/O, it holds one flag per channel that says whether the pin drives its analog level or is left in the high-impedance input state. The resistor ladders and amplifiers sit outside the block and read its code buses. The enable flags tell the pin logic which of the shared pins to hand to the analog side.

Commands come from an upstream serial front end. That front end raises a one-cycle execute strobe together with a 4-bit channel field and a 12-bit data field. Channel values 1 to 12 address a single channel. Channel value 0 acts on every channel at once: it can broadcast a level, send the shared pins to high impedance, or restore the power-on state. When it restores the power-on state, the block emits a one-cycle reset strobe for its neighbours. Channel values 13 to 15 belong to the expander logic, and this block ignores them.

Top module: `dac_code_bank`

## Requirements
- R1: After reset every channel code is 0, every analog-enable flag is 0 and the global reset strobe is low.
- R2: The data field is split as follows: bits 11..4 carry the level and bits 3..0 carry the sub-operation. An executed command with channel value c in 1..12 and sub-operation 0 loads the level into channel c only. Channel c's code appears on `codes[(c-1)*8 +: 8]`.
- R3: An executed command with channel 0 and sub-operation 0 loads the same level into all twelve channels and sets all eight analog-enable flags.
- R4: A level write to channel c in 5..12 sets `ana_en[c-5]`. A level write to channels 1..4 leaves every flag as it was.
- R5: A command with sub-operation 1 sent to channel c in 5..12 clears `ana_en[c-5]` and leaves every code unchanged. Sent to channels 1..4, it changes nothing.
- R6: A command with channel 0 and sub-operation 1 clears all analog-enable flags and leaves every code unchanged.
- R7: A command with channel 0 and sub-operation 2 clears all codes and all flags. It also drives `glob_rst` high for exactly the one cycle that follows the executing edge.
- R8: Commands with channel values 13, 14 or 15 change no code and no flag, and they do not raise `glob_rst`.
- R9: Sub-operation values 3..15 have no effect on any channel. Sub-operation 2 sent to a single channel also has no effect.
- R10: State changes only on a clock edge where `exec` is high, and the new value is visible from that edge onward. The fields are ignored while `exec` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Execute strobe, one cycle per command |
| chan | input | 4 | Channel field of the command |
| cmd_data | input | 12 | Level in bits 11..4, sub-operation in bits 3..0 |
| codes | output | 96 | Twelve 8-bit channel codes, channel 1 in the low byte |
| ana_en | output | 8 | Analog-enable flags for channels 5..12, bit 0 is channel 5 |
| glob_rst | output | 1 | One-cycle strobe after a global reset command |

## Verification
Three cases are hard to reach from the ports. The first is a high-impedance request that must take effect on a channel whose flag is already set while leaving its stored code untouched. The second is the same request sent to a channel that has no flag at all. The third is a global reset that lands on a bank already full of non-zero codes. The stimulus reaches these cases by first filling every channel with distinct levels through single writes. It then applies the high-impedance and reset commands on top of that state, so a lost code or a stray flag change shows up on the output buses. Commands with ignored channel values and ignored sub-operations are also sent over a fully loaded bank, for the same reason.

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
  parameter int NCH     = 12,
  parameter int CW      = 8,
  parameter int SW      = 4,
  parameter int CHW     = 4,
  parameter int DUAL_LO = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec,
  input  logic [CHW-1:0]        chan,
  input  logic [CW+SW-1:0]      cmd_data,
  output logic [NCH*CW-1:0]     codes,
  output logic [NCH-DUAL_LO:0]  ana_en,
  output logic                  glob_rst
);
  localparam int NDUAL = NCH - DUAL_LO + 1;
  localparam logic [SW-1:0] OP_LVL = SW'(0);
  localparam logic [SW-1:0] OP_HIZ = SW'(1);
  localparam logic [SW-1:0] OP_RST = SW'(2);

  logic [CW-1:0] lvl;
  logic [SW-1:0] op;
  logic          bcast;

  assign lvl   = cmd_data[CW+SW-1:SW];
  assign op    = cmd_data[SW-1:0];
  assign bcast = exec && (chan == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic [CW-1:0] code_q;
    assign hit = exec && (chan == CHW'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              code_q <= '0;
      else if (bcast && op == OP_RST)          code_q <= '0;
      else if ((bcast || hit) && op == OP_LVL) code_q <= lvl;
    end
    assign codes[i*CW +: CW] = code_q;

    if (i >= DUAL_LO - 1) begin : g_dual
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ana_en[i-DUAL_LO+1] <= 1'b0;
        else if (bcast && op == OP_RST)          ana_en[i-DUAL_LO+1] <= 1'b0;
        else if ((bcast || hit) && op == OP_HIZ) ana_en[i-DUAL_LO+1] <= 1'b0;
        else if ((bcast || hit) && op == OP_LVL) ana_en[i-DUAL_LO+1] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_rst <= 1'b0;
    else        glob_rst <= bcast && (op == OP_RST);
  end

  logic unused_ok;
  assign unused_ok = (NDUAL > 0);
endmodule

module dac_code_bank_chk #(
  parameter int NCH     = 12,
  parameter int CW      = 8,
  parameter int SW      = 4,
  parameter int CHW     = 4,
  parameter int DUAL_LO = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  exec,
  input logic [CHW-1:0]        chan,
  input logic [CW+SW-1:0]      cmd_data,
  input logic [NCH*CW-1:0]     codes,
  input logic [NCH-DUAL_LO:0]  ana_en,
  input logic                  glob_rst
);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(codes) && $stable(ana_en) && !glob_rst);

  a_r3_broadcast_level: assert property (@(posedge clk) disable iff (!rst_n)
    exec && chan == '0 && cmd_data[SW-1:0] == '0
    |=> codes == {NCH{$past(cmd_data[CW+SW-1:SW])}} && (&ana_en));

  a_r6_hiz_all: assert property (@(posedge clk) disable iff (!rst_n)
    exec && chan == '0 && cmd_data[SW-1:0] == SW'(1)
    |=> ana_en == '0 && $stable(codes));

  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    glob_rst |-> codes == '0 && ana_en == '0);

  a_r8_expander_codes: assert property (@(posedge clk) disable iff (!rst_n)
    exec && chan > CHW'(NCH) |=> $stable(codes) && $stable(ana_en) && !glob_rst);

  a_r5_low_hiz_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    exec && chan != '0 && chan < CHW'(DUAL_LO) && cmd_data[SW-1:0] == SW'(1)
    |=> $stable(codes) && $stable(ana_en));

  a_r4_level_enables: assert property (@(posedge clk) disable iff (!rst_n)
    exec && chan == CHW'(DUAL_LO) && cmd_data[SW-1:0] == '0 |=> ana_en[0]);
endmodule

bind dac_code_bank dac_code_bank_chk #(
  .NCH(NCH), .CW(CW), .SW(SW), .CHW(CHW), .DUAL_LO(DUAL_LO)
) u_chk (.*);

// File: tb/test_dac_code_bank.sv
module test_dac_code_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [3:0]  chan = '0;
  logic [11:0] cmd_data = '0;
  logic [95:0] codes;
  logic [7:0]  ana_en;
  logic        glob_rst;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_code [12];
  logic [7:0] exp_en;

  dac_code_bank i_dac_code_bank (
    .clk(clk), .rst_n(rst_n), .exec(exec), .chan(chan), .cmd_data(cmd_data),
    .codes(codes), .ana_en(ana_en), .glob_rst(glob_rst)
  );

  always #4 clk = ~clk;

  function automatic logic [95:0] exp_bus();
    logic [95:0] b;
    for (int i = 0; i < 12; i++) b[i*8 +: 8] = exp_code[i];
    return b;
  endfunction

  task automatic verify(input string req, input logic exp_pulse);
    checks++;
    if (codes !== exp_bus()) begin
      errors++;
      $display("FAIL %s codes actual=%h expected=%h", req, codes, exp_bus());
    end
    checks++;
    if (ana_en !== exp_en) begin
      errors++;
      $display("FAIL %s ana_en actual=%b expected=%b", req, ana_en, exp_en);
    end
    checks++;
    if (glob_rst !== exp_pulse) begin
      errors++;
      $display("FAIL %s glob_rst actual=%b expected=%b", req, glob_rst, exp_pulse);
    end
  endtask

  task automatic cmd(input logic [3:0] ch, input logic [7:0] lv, input logic [3:0] op,
                     input string req);
    exec = 1'b1; chan = ch; cmd_data = {lv, op};
    @(negedge clk);
    exec = 1'b0;
    if (ch == 4'd0) begin
      if (op == 4'd0) begin
        for (int i = 0; i < 12; i++) exp_code[i] = lv;
        exp_en = '1;
      end else if (op == 4'd1) begin
        exp_en = '0;
      end else if (op == 4'd2) begin
        for (int i = 0; i < 12; i++) exp_code[i] = '0;
        exp_en = '0;
      end
    end else if (ch <= 4'd12) begin
      if (op == 4'd0) begin
        exp_code[ch-1] = lv;
        if (ch >= 4'd5) exp_en[ch-5] = 1'b1;
      end else if (op == 4'd1 && ch >= 4'd5) begin
        exp_en[ch-5] = 1'b0;
      end
    end
    verify(req, ch == 4'd0 && op == 4'd2);
  endtask

  task automatic fill_all();
    for (int c = 1; c <= 12; c++) cmd(4'(c), 8'(c * 17 + 3), 4'd0, "R2");
  endtask

  task automatic t_reset();
    for (int i = 0; i < 12; i++) exp_code[i] = '0;
    exp_en = '0;
    verify("R1", 1'b0);
  endtask

  task automatic t_single();
    cmd(4'd1, 8'hA5, 4'd0, "R2");
    cmd(4'd4, 8'hFF, 4'd0, "R4");
    cmd(4'd5, 8'h01, 4'd0, "R4");
    cmd(4'd12, 8'h80, 4'd0, "R4");
    fill_all();
  endtask

  task automatic t_hiz_single();
    cmd(4'd7, 8'h00, 4'd1, "R5");
    cmd(4'd12, 8'h33, 4'd1, "R5");
    cmd(4'd2, 8'h00, 4'd1, "R5");
    cmd(4'd7, 8'h44, 4'd0, "R4");
  endtask

  task automatic t_ignored();
    cmd(4'd13, 8'h11, 4'd0, "R8");
    cmd(4'd14, 8'h22, 4'd1, "R8");
    cmd(4'd15, 8'h33, 4'd2, "R8");
    cmd(4'd3, 8'h55, 4'd2, "R9");
    cmd(4'd9, 8'h66, 4'd7, "R9");
    cmd(4'd0, 8'h77, 4'd15, "R9");
    cmd(4'd0, 8'h78, 4'd3, "R9");
  endtask

  task automatic t_no_exec();
    chan = 4'd0; cmd_data = {8'hEE, 4'd2};
    repeat (3) @(negedge clk);
    verify("R10", 1'b0);
    chan = 4'd6; cmd_data = {8'h12, 4'd0};
    @(negedge clk);
    verify("R10", 1'b0);
  endtask

  task automatic t_broadcast();
    cmd(4'd0, 8'h5C, 4'd0, "R3");
    cmd(4'd8, 8'h00, 4'd1, "R5");
    cmd(4'd0, 8'hC3, 4'd0, "R3");
  endtask

  task automatic t_hiz_all();
    fill_all();
    cmd(4'd0, 8'h00, 4'd1, "R6");
  endtask

  task automatic t_global_reset();
    fill_all();
    cmd(4'd0, 8'hFF, 4'd2, "R7");
    @(negedge clk);
    verify("R7", 1'b0);
    cmd(4'd0, 8'h00, 4'd2, "R7");
    cmd(4'd10, 8'h9A, 4'd0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_hiz_single();
    t_ignored();
    t_no_exec();
    t_broadcast();
    t_hiz_all();
    t_global_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule